// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a 16-bit successive-approximation converter. While idle it holds the sampling switches closed, so the input is being acquired. A rising edge on the convert input ends acquisition. The controller first spends one cycle with the sampling switches open and the DAC bus at zero. It then searches the code from the most significant bit down. For each bit it places a trial word on the binary-weighted DAC bus, waits a set number of internal clocks, and reads the comparator. It keeps the bit if the input is at or above the trial level and clears it otherwise.

After the least significant decision, the code is latched on the output, a one-cycle done pulse is raised, and the block falls back to acquisition until the next edge. The search pins inputs above the reference to the all-ones code and inputs below ground to the all-zeros code. The code is available as soon as the conversion ends, with no pipeline delay. Timing comes only from the block's own clock; no serial clock is involved.

Top module: `sar_ctrl`

## Requirements
- R1: During and after reset, busy_o=0, done_o=0, code_o=0, dac_o=0 and sample_o=1.
- R2: A rising edge of start_i sampled while idle gives busy_o=1 and sample_o=0 in the next cycle. Keeping start_i high does not start another conversion.
- R3: The first busy cycle is a hold step. In it sample_o=0 and dac_o=0, so no trial bit is applied.
- R4: The first trial word on dac_o is 0x8000, with only bit 15 set. Bits are then tried one at a time, from bit 15 down to bit 0.
- R5: While a bit is under test, dac_o equals the bits kept so far OR the bit under test. At the end of the test window, the bit is kept when cmp_i=1 (input at or above the trial level) and cleared when cmp_i=0.
- R6: code_o is straight binary. An input equal to code N converts to N; for example midscale gives 0x8000, and one LSB below midscale gives 0x7FFF.
- R7: An input above full scale converts to 0xFFFF, and an input below zero converts to 0x0000.
- R8: done_o pulses for exactly one cycle. In that cycle the new code is on code_o, busy_o=0 and sample_o=1.
- R9: busy_o stays high for exactly 1 + 16*CLKS_PER_BIT cycles per conversion (33 with default parameters). This is within the bench's limit.
- R10: A start_i edge that arrives while busy_o=1 is ignored. The running conversion ends with its own code and produces one done pulse.
- R11: code_o holds its value between done pulses, whatever cmp_i and start_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Convert request; a rising edge ends acquisition |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the DAC level |
| dac_o | output | 16 | Binary-weighted DAC switch word |
| sample_o | output | 1 | Sampling switches closed (acquisition) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new code is latched |
| code_o | output | 16 | Last conversion result, straight binary |

## Verification
A wrong bit decision or a misordered trial mask shows on dac_o within one test window, at most CLKS_PER_BIT cycles later. The bench probes the DAC word in the hold cycle, at the first trial and at the second trial. A state machine that stalls, restarts or leaves early shows at the done pulse: the busy length moves away from 1 + 16*CLKS_PER_BIT, or the latched code differs from the clamped input expected by the scoreboard. A restart on a mid-conversion edge would show as an extra done pulse or a busy level that never drops while start_i is held high.

// File: rtl/sar_pkg.sv
// sar_pkg: shared types of the successive-approximation controller.
// Assumes: imported by every module of the block.
package sar_pkg;
    // Phases of one conversion
    typedef enum logic [1:0] {
        PH_ACQ  = 2'd0,   // sampling switches closed, waiting for an edge
        PH_HOLD = 2'd1,   // switches open, no trial bit yet
        PH_CONV = 2'd2    // bit-by-bit search
    } sar_phase_t;
endpackage

// File: rtl/sar_edge.sv
// sar_edge: rising-edge detector on the convert request.
// Assumes: the request is already synchronous to clk.
module sar_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    logic req_q;

    // Remember the last level of the request
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_i;
    end

    assign rise_o = req_i & ~req_q;
endmodule

// File: rtl/sar_pacer.sv
// sar_pacer: divides clk into decision strobes, one every TICKS cycles.
// Assumes: clr_i restarts the window; tick_o is only valid while run_i is high.
module sar_pacer #(
    parameter int unsigned TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW    = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int unsigned LASTI = TICKS - 1;
    localparam logic [CW-1:0] LAST = LASTI[CW-1:0];

    logic [CW-1:0] cnt_q;

    // Count clocks within one decision window
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt_q <= '0;
        else if (run_i)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_reg.sv
// sar_reg: successive-approximation register with a one-hot trial mask.
// Assumes: load_i starts a search at the MSB; step_i applies one decision.
module sar_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] kept_o,
    output logic             last_o,
    output logic [WIDTH-1:0] next_o
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] trial_q;
    logic [WIDTH-1:0] kept_q;

    // Keep the bit under test when the comparator says input >= trial level
    assign next_o = cmp_i ? (kept_q | trial_q) : kept_q;

    // Advance the search one bit per decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q <= '0;
            kept_q  <= '0;
        end else if (load_i) begin
            trial_q <= MSB_ONLY;
            kept_q  <= '0;
        end else if (step_i) begin
            kept_q  <= next_o;
            trial_q <= trial_q >> 1;
        end
    end

    assign trial_o = trial_q;
    assign kept_o  = kept_q;
    assign last_o  = trial_q[0];
endmodule

// File: rtl/sar_ctrl.sv
// sar_ctrl: top of the successive-approximation controller.
// Sequences acquisition, a hold step and WIDTH decisions, then latches the code.
// Assumes: start_i and cmp_i are synchronous to clk; cmp_i follows dac_o
// within one decision window.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH        = 16,
    parameter int unsigned CLKS_PER_BIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_o,
    output logic             sample_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] code_o
);
    sar_phase_t       phase_q;
    logic             rise;
    logic             tick;
    logic             last;
    logic [WIDTH-1:0] trial;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] next_code;
    logic             in_conv;
    logic             finish;
    logic             done_q;
    logic [WIDTH-1:0] code_q;

    assign in_conv = (phase_q == PH_CONV);
    assign finish  = in_conv && tick && last;

    sar_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (start_i),
        .rise_o (rise)
    );

    sar_pacer #(.TICKS(CLKS_PER_BIT)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (phase_q == PH_HOLD),
        .run_i  (in_conv),
        .tick_o (tick)
    );

    sar_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (phase_q == PH_HOLD),
        .step_i  (in_conv && tick),
        .cmp_i   (cmp_i),
        .trial_o (trial),
        .kept_o  (kept),
        .last_o  (last),
        .next_o  (next_code)
    );

    // Phase sequencing: edges are only accepted during acquisition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ACQ;
        end else begin
            case (phase_q)
                PH_ACQ:  if (rise)   phase_q <= PH_HOLD;
                PH_HOLD:             phase_q <= PH_CONV;
                PH_CONV: if (finish) phase_q <= PH_ACQ;
                default:             phase_q <= PH_ACQ;
            endcase
        end
    end

    // Latch the final code and pulse done as the search ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) code_q <= next_code;
        end
    end

    assign dac_o    = in_conv ? (kept | trial) : '0;
    assign sample_o = (phase_q == PH_ACQ);
    assign busy_o   = (phase_q != PH_ACQ);
    assign done_o   = done_q;
    assign code_o   = code_q;
endmodule

// File: rtl/sar_ctrl_chk.sv
// sar_ctrl_chk: port-level properties of sar_ctrl, attached with bind.
// Assumes: same parameters as the bound instance.
module sar_ctrl_chk #(
    parameter int unsigned WIDTH        = 16,
    parameter int unsigned CLKS_PER_BIT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] dac_o,
    input logic             sample_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] code_o
);
    localparam int unsigned CONV_CYCLES = 1 + WIDTH * CLKS_PER_BIT;
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic        start_q;
    int unsigned busy_cnt;

    // Own copy of the request level and a busy-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            busy_cnt <= 0;
        end else begin
            start_q  <= start_i;
            busy_cnt <= busy_o ? busy_cnt + 1 : 0;
        end
    end

    AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !start_q) |=> (busy_o && !sample_o)); // R2

    AST_HOLD_NO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (dac_o == '0 && !sample_o)); // R3

    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> (dac_o == MSB_ONLY)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && sample_o)); // R8

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == CONV_CYCLES)); // R9

    AST_NO_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R10

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(code_o)); // R11
endmodule

bind sar_ctrl sar_ctrl_chk #(
    .WIDTH        (WIDTH),
    .CLKS_PER_BIT (CLKS_PER_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .dac_o    (dac_o),
    .sample_o (sample_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .code_o   (code_o)
);

// File: tb/sar_ctrl_test.sv
`timescale 1ns/1ps
// sar_ctrl_test: scoreboard bench. A driver task sets the analog level,
// pushes the expected code and fires a start edge; a monitor pops at done.
module sar_ctrl_test;
    localparam int WIDTH        = 16;
    localparam int CLKS_PER_BIT = 2;
    localparam int CONV_CYCLES  = 1 + WIDTH * CLKS_PER_BIT;
    localparam int CONV_LIMIT   = 40;
    localparam int WD_CYCLES    = 20000;
    localparam int FULL         = (1 << WIDTH) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             cmp_i;
    logic [WIDTH-1:0] dac_o;
    logic             sample_o;
    logic             busy_o;
    logic             done_o;
    logic [WIDTH-1:0] code_o;

    int    vin = 0;
    int    errors = 0;
    int    checks = 0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    // Behavioural comparator against the analog level
    assign cmp_i = (vin >= int'(dac_o));

    sar_ctrl #(.WIDTH(WIDTH), .CLKS_PER_BIT(CLKS_PER_BIT)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmp_i    (cmp_i),
        .dac_o    (dac_o),
        .sample_o (sample_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .code_o   (code_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v < 0)    return 0;
        if (v > FULL) return FULL;
        return v;
    endfunction

    // Monitor: busy length, single-cycle done, and code against the queue
    int  busy_cnt = 0;
    bit  done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            if (done_o) begin
                check(!done_prev, "R8 done single cycle", 1, 0);
                check(!busy_o && sample_o, "R8 idle at done", busy_o, 0);
                check(busy_cnt == CONV_CYCLES, "R9 busy length", busy_cnt, CONV_CYCLES);
                check(busy_cnt <= CONV_LIMIT, "R9 conversion limit", busy_cnt, CONV_LIMIT);
                busy_cnt = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", code_o, -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(code_o) == e, t, code_o, e);
                end
            end
            done_prev = done_o;
        end
    end

    // Driver: one conversion; glitch adds a start edge mid-conversion
    task automatic convert(input int level, input string tag, input bit glitch);
        int second;
        vin = level;
        exp_q.push_back(clamp(level));
        tag_q.push_back(tag);
        start_i = 1'b1;
        @(negedge clk);
        check(busy_o && !sample_o, "R2 start edge", busy_o, 1);
        check(dac_o == '0, "R3 hold step dac", dac_o, 0);
        @(negedge clk);
        check(dac_o == 16'h8000, "R4 first trial", dac_o, 16'h8000);
        start_i = 1'b0;
        repeat (CLKS_PER_BIT) @(negedge clk);
        second = ((level >= 32768) ? 32768 : 0) | 16384;
        check(int'(dac_o) == second, "R5 second trial", dac_o, second);
        if (glitch) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        if (glitch) begin
            repeat (4) @(negedge clk);
            check(!busy_o, "R10 edge ignored, R2 level no restart", busy_o, 0);
            start_i = 1'b0;
            @(negedge clk);
        end
    endtask

    // Watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", WD_CYCLES, WD_CYCLES);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus
    initial begin
        int held;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && code_o == '0 && dac_o == '0 && sample_o,
              "R1 reset state", {busy_o, done_o, sample_o}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && sample_o, "R1 idle after reset", busy_o, 0);

        convert(32768, "R6 midscale", 1'b0);
        convert(32767, "R6 midscale minus one", 1'b0);
        convert(65535, "R6 full scale", 1'b0);
        convert(1,     "R6 one LSB", 1'b0);
        convert(0,     "R6 zero", 1'b0);
        convert(16'h1234, "R6 pattern 1234", 1'b0);
        convert(16'hA5A5, "R6 pattern A5A5", 1'b0);
        convert(70000, "R7 overrange", 1'b0);
        convert(-3,    "R7 underrange", 1'b0);
        convert(16'h5A5A, "R10 glitch conversion", 1'b1);

        held = code_o;
        vin = 100;
        repeat (10) @(negedge clk);
        check(int'(code_o) == held, "R11 code holds", code_o, held);
        check(exp_q.size() == 0, "R8 all codes delivered", exp_q.size(), 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule